// File: doc/BRIEF.md
# Hash Block Loader

This block is the input front end of a message-digest accelerator. A single word port receives the message as a stream of 32-bit writes, which may come from a processor or from a DMA channel. The words fill a sixteen-entry staging buffer. When the buffer holds a whole 64-byte block, the loader copies it into a working register that feeds the compression core. It then pulses the core's start line and reopens the staging buffer, so the next block can load while the core is still working.

A hash begins with a start pulse, which also carries the message length in bytes. The loader adds up the bytes it hands to the core. Once the running total reaches the programmed length, the block just handed over is marked as the last one and input closes. A close request can also launch a short final block that holds only the words written so far. When the core reports done for the last block, output-ready is set, and an active-low completion interrupt follows it if that interrupt is enabled. Three separate controls decide how the next block is requested:
- a DMA mode bit
- a DMA request mask
- the processor interrupt enables

Top module: `hash_block_loader`

## Requirements
- R1: After reset, in_rdy, out_rdy, overrun, dma_req, core_start and cpu_irq are 0 and done_irq_n is 1.
- R2: One cycle after a cfg_start pulse, in_rdy is 1 whatever the interrupt enables are. The same pulse clears out_rdy, overrun and msg_bytes.
- R3: Accepted writes fill word slots 0 to 15 in order. The sixteenth accepted write launches the block. During the one-cycle core_start pulse, core_blk bits [32k+31:32k] hold word k and core_nbytes is 64.
- R4: in_rdy is 0 in the cycle after the sixteenth write. When the core is busy, a full buffer holds its block and keeps in_rdy at 0 until core_done arrives, and then the held block is launched.
- R5: A write while in_rdy is 0 is ignored and sets the sticky overrun flag. A clr_ovr pulse or a cfg_start pulse clears the flag.
- R6: A close_req with n pending words launches a final block with core_nbytes = 4n and core_last = 1. The n words include a write accepted in the same cycle. A close_req with no pending word does nothing.
- R7: msg_bytes grows by 64 per full block and by 4n per closed block, and it is updated when the block is launched. A block after which msg_bytes ≥ cfg_len is the last one.
- R8: out_rdy is set after core_done for the last block, and not after core_done for any earlier block. in_rdy then stays 0, and ack_done clears out_rdy.
- R9: done_irq_n is 0 exactly when out_rdy and comp_irq_en are both 1.
- R10: dma_req is a one-cycle pulse on each rise of in_rdy while dma_en and dma_mask are both 1. No pulse occurs when either is 0. A two-block hash therefore gives two pulses.
- R11: cpu_irq is (ie_in AND in_rdy) OR (ie_out AND out_rdy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Begin a new hash |
| cfg_len | input | CNT_W | Message length in bytes |
| dma_en | input | 1 | DMA mode |
| dma_mask | input | 1 | DMA request mask |
| comp_irq_en | input | 1 | Completion interrupt enable |
| ie_in | input | 1 | Processor interrupt enable for input-ready |
| ie_out | input | 1 | Processor interrupt enable for output-ready |
| wr_en | input | 1 | Word write strobe |
| wr_data | input | WORD_W | Word written |
| close_req | input | 1 | Dispatch a partial final block |
| ack_done | input | 1 | Write-1 clear of out_rdy |
| clr_ovr | input | 1 | Write-1 clear of overrun |
| core_done | input | 1 | Core has finished the current block |
| in_rdy | output | 1 | Buffer can take words |
| out_rdy | output | 1 | Hash complete (sticky) |
| overrun | output | 1 | A write was dropped (sticky) |
| dma_req | output | 1 | Request for the next block |
| cpu_irq | output | 1 | Masked processor interrupt |
| done_irq_n | output | 1 | Active-low completion interrupt |
| core_start | output | 1 | Block launch pulse |
| core_blk | output | WORDS*WORD_W | Working copy of the block |
| core_nbytes | output | log2(block bytes)+1 | Valid bytes in the block |
| core_last | output | 1 | Block is the final one |
| msg_bytes | output | CNT_W | Bytes handed to the core |

## Verification
The bench sweeps the close request over every fill level from 1 to 15 words. It alternates between a close in its own cycle and a close alongside the last write. An off-by-one in the pending count would show up as a core_nbytes four bytes short. A slow core model lets a second block back up behind a busy core. A design that overwrote the working copy or kept in_rdy high would corrupt the second block or accept the extra word that should be dropped. Lengths equal to one, two and three whole blocks, plus one ending in a partial block, catch completion raised one block early. DMA requests are counted per hash under each mode and mask setting to catch a request repeated on every word.

// File: rtl/hash_block_loader.sv
module hash_block_loader #(
  parameter int WORDS  = 16,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_start,
  input  logic [CNT_W-1:0]                       cfg_len,
  input  logic                                   dma_en,
  input  logic                                   dma_mask,
  input  logic                                   comp_irq_en,
  input  logic                                   ie_in,
  input  logic                                   ie_out,
  input  logic                                   wr_en,
  input  logic [WORD_W-1:0]                      wr_data,
  input  logic                                   close_req,
  input  logic                                   ack_done,
  input  logic                                   clr_ovr,
  input  logic                                   core_done,
  output logic                                   in_rdy,
  output logic                                   out_rdy,
  output logic                                   overrun,
  output logic                                   dma_req,
  output logic                                   cpu_irq,
  output logic                                   done_irq_n,
  output logic                                   core_start,
  output logic [WORDS*WORD_W-1:0]                core_blk,
  output logic [$clog2(WORDS*WORD_W/8):0]        core_nbytes,
  output logic                                   core_last,
  output logic [CNT_W-1:0]                       msg_bytes
);
  localparam int PW    = $clog2(WORDS);
  localparam int BB    = WORD_W / 8;
  localparam int BLK_B = WORDS * BB;
  localparam int NBW   = $clog2(BLK_B) + 1;

  logic [WORD_W-1:0] blk_q [WORDS];
  logic [PW-1:0]     wptr;
  logic [NBW-1:0]    nb_q, core_nb_q;
  logic [CNT_W-1:0]  cnt;
  logic active, full_q, close_q, busy, fin_q, in_rdy_q, out_q, ovr_q, start_q, last_q;

  assign in_rdy = active & ~full_q;

  logic             acc, fill_last, do_close, launch, is_last;
  logic [PW:0]      pend;
  logic [CNT_W-1:0] cnt_nx;

  assign acc       = wr_en & in_rdy;
  assign pend      = {1'b0, wptr} + {{PW{1'b0}}, acc};
  assign fill_last = acc && (wptr == PW'(WORDS - 1));
  assign do_close  = close_req && in_rdy && !fill_last && (pend != '0);
  assign launch    = full_q && !busy;
  assign cnt_nx    = cnt + CNT_W'(nb_q);
  assign is_last   = close_q || (cnt_nx >= cfg_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; nb_q <= '0; core_nb_q <= '0; cnt <= '0;
      active <= 1'b0; full_q <= 1'b0; close_q <= 1'b0; busy <= 1'b0;
      fin_q <= 1'b0; in_rdy_q <= 1'b0; out_q <= 1'b0; ovr_q <= 1'b0;
      start_q <= 1'b0; last_q <= 1'b0;
    end else begin
      start_q  <= launch;
      in_rdy_q <= in_rdy;
      if (launch)              busy <= 1'b1;
      else if (core_done)      busy <= 1'b0;
      if (cfg_start) begin
        active <= 1'b1; wptr <= '0; full_q <= 1'b0; close_q <= 1'b0;
        cnt <= '0; out_q <= 1'b0; ovr_q <= 1'b0; fin_q <= 1'b0;
      end else begin
        if (wr_en && !in_rdy)  ovr_q <= 1'b1;
        else if (clr_ovr)      ovr_q <= 1'b0;
        if (fill_last) begin
          full_q <= 1'b1; wptr <= '0; close_q <= 1'b0; nb_q <= NBW'(BLK_B);
        end else if (do_close) begin
          full_q <= 1'b1; wptr <= '0; close_q <= 1'b1; nb_q <= NBW'(32'(pend) * BB);
        end else if (acc) begin
          wptr <= wptr + PW'(1);
        end
        if (launch) begin
          full_q    <= 1'b0;
          cnt       <= cnt_nx;
          core_nb_q <= nb_q;
          last_q    <= is_last;
          if (is_last) begin
            active <= 1'b0;
            fin_q  <= 1'b1;
          end
        end
        if (core_done && busy && fin_q) begin
          out_q <= 1'b1;
          fin_q <= 1'b0;
        end else if (ack_done) begin
          out_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc) blk_q[wptr] <= wr_data;
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_work
    always_ff @(posedge clk) begin
      if (launch) core_blk[k*WORD_W +: WORD_W] <= blk_q[k];
    end
  end

  assign core_start  = start_q;
  assign core_nbytes = core_nb_q;
  assign core_last   = last_q;
  assign msg_bytes   = cnt;
  assign out_rdy     = out_q;
  assign overrun     = ovr_q;
  assign dma_req     = dma_en & dma_mask & in_rdy & ~in_rdy_q;
  assign cpu_irq     = (ie_in & in_rdy) | (ie_out & out_q);
  assign done_irq_n  = ~(out_q & comp_irq_en);
endmodule

// File: rtl/hash_block_loader_chk.sv
module hash_block_loader_chk #(
  parameter int WORDS  = 16,
  parameter int WORD_W = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cfg_start,
  input logic                            wr_en,
  input logic                            in_rdy,
  input logic                            overrun,
  input logic                            core_start,
  input logic                            core_last,
  input logic [$clog2(WORDS*WORD_W/8):0] core_nbytes,
  input logic                            dma_req,
  input logic                            dma_en,
  input logic                            dma_mask,
  input logic                            done_irq_n,
  input logic                            out_rdy,
  input logic                            comp_irq_en
);
  localparam int BB    = WORD_W / 8;
  localparam int BLK_B = WORDS * BB;

  // R5
  drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_rdy && !cfg_start) |=> overrun);
  // R4
  launch_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> $past(!in_rdy));
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  // R3
  full_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start && !core_last) |-> (int'(core_nbytes) == BLK_B));
  // R6
  close_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> (core_nbytes != '0 && int'(core_nbytes) <= BLK_B && (int'(core_nbytes) % BB) == 0));
  // R10
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (in_rdy && dma_en && dma_mask));
  // R10
  dma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_irq_n |-> (out_rdy && comp_irq_en));
  // R8
  done_closes_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_rdy) |-> !in_rdy);
endmodule

bind hash_block_loader hash_block_loader_chk #(.WORDS(WORDS), .WORD_W(WORD_W)) chk_i (.*);

// File: tb/hash_block_loader_tb_top.sv
module hash_block_loader_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_start = 0, dma_en = 0, dma_mask = 0, comp_irq_en = 0, ie_in = 0, ie_out = 0;
  logic wr_en = 0, close_req = 0, ack_done = 0, clr_ovr = 0, core_done = 0;
  logic [31:0] cfg_len = 0, wr_data = 0;
  logic in_rdy, out_rdy, overrun, dma_req, cpu_irq, done_irq_n, core_start, core_last;
  logic [511:0] core_blk;
  logic [6:0]   core_nbytes;
  logic [31:0]  msg_bytes;

  always #10 clk = ~clk;

  hash_block_loader dut_i (.*);

  int npass = 0, nfail = 0, starts = 0, dmas = 0, lat = 3, cd = 0;
  logic [511:0] cap_blk;
  logic [6:0]   cap_nb;
  logic         cap_last;

  always @(posedge clk) begin
    core_done <= 1'b0;
    if (cd > 0) begin
      cd = cd - 1;
      if (cd == 0) core_done <= 1'b1;
    end
    if (core_start) begin
      starts = starts + 1; cap_blk = core_blk; cap_nb = core_nbytes; cap_last = core_last; cd = lat;
    end
    if (dma_req) dmas = dmas + 1;
  end

  function automatic logic [31:0] pat(int b, int i);
    return (32'(b) * 32'h0001_0003) ^ (32'(i) * 32'h0101_0101) ^ 32'hC3A5_0000;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    if (ok && act == exp) npass++;
    else begin nfail++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", npass, npass + nfail);
    $finish;
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic start(int len);
    @(negedge clk); cfg_len = len; cfg_start = 1;
    @(negedge clk); cfg_start = 0;
  endtask

  task automatic send(int b, int n, bit close_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_en = 1; wr_data = pat(b, i); close_req = close_last && (i == n - 1);
    end
    @(negedge clk); wr_en = 0; close_req = 0;
  endtask

  task automatic pulse_close();
    @(negedge clk); close_req = 1; @(negedge clk); close_req = 0;
  endtask

  task automatic wait_start(int target);
    for (int i = 0; i < 500 && starts < target; i++) @(negedge clk);
  endtask

  task automatic wait_out();
    for (int i = 0; i < 500 && !out_rdy; i++) @(negedge clk);
  endtask

  task automatic check_blk(string req, int b, int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (cap_blk[i*32 +: 32] !== pat(b, i)) bad++;
    chk(1, req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; $display("FAIL watchdog: run hung");
    summary();
  end

  initial begin
    int s0, d0;
    cyc(3);
    // R1 reset state
    chk(1, "R1 in_rdy", in_rdy, 0);    chk(1, "R1 out_rdy", out_rdy, 0);
    chk(1, "R1 overrun", overrun, 0);  chk(1, "R1 done_irq_n", done_irq_n, 1);
    chk(1, "R1 dma_req", dma_req, 0);  chk(1, "R1 core_start", core_start, 0);
    chk(1, "R1 cpu_irq", cpu_irq, 0);
    rst_n = 1; cyc(2);

    // R5 write before any hash is dropped
    send(0, 1, 0);
    chk(1, "R5 overrun set", overrun, 1); chk(1, "R5 no launch", starts, 0);
    @(negedge clk); clr_ovr = 1; @(negedge clk); clr_ovr = 0;
    chk(1, "R5 clr_ovr", overrun, 0);

    // two-block hash with DMA
    dma_en = 1; dma_mask = 1; comp_irq_en = 1; lat = 5; d0 = dmas;
    start(128);
    chk(1, "R2 in_rdy after start", in_rdy, 1);
    chk(1, "R10 dma_req on start", dma_req, 1);
    chk(1, "R11 cpu_irq masked", cpu_irq, 0);
    ie_in = 1; #1 chk(1, "R11 cpu_irq in", cpu_irq, 1); ie_in = 0;
    send(1, 16, 0);
    chk(1, "R4 in_rdy low after 16th", in_rdy, 0);
    cyc(1);
    chk(1, "R3 core_start", core_start, 1);
    chk(1, "R3 nbytes", core_nbytes, 64);
    chk(1, "R7 msg_bytes 64", msg_bytes, 64);
    chk(1, "R7 not last", core_last, 0);
    chk(1, "R10 dma_req reopen", dma_req, 1);
    cyc(lat + 4);
    chk(1, "R8 no early out_rdy", out_rdy, 0);
    check_blk("R3 block 1", 1, 16);
    send(2, 16, 0); wait_start(2);
    chk(1, "R7 second is last", cap_last, 1);
    check_blk("R3 block 2", 2, 16);
    wait_out(); cyc(1);
    chk(1, "R8 out_rdy", out_rdy, 1);
    chk(1, "R8 input closed", in_rdy, 0);
    chk(1, "R9 irq low", done_irq_n, 0);
    chk(1, "R7 msg_bytes 128", msg_bytes, 128);
    chk(1, "R10 two requests", dmas - d0, 2);
    ie_out = 1; #1 chk(1, "R11 cpu_irq out", cpu_irq, 1); ie_out = 0;
    @(negedge clk); ack_done = 1; @(negedge clk); ack_done = 0;
    chk(1, "R8 ack clears", out_rdy, 0);
    chk(1, "R9 irq released", done_irq_n, 1);

    // DMA mode off
    dma_en = 0; d0 = dmas;
    start(64);
    chk(1, "R10 no req when off", dma_req, 0);
    send(3, 16, 0); wait_out(); cyc(1);
    chk(1, "R7 one block hash", out_rdy, 1);
    comp_irq_en = 0; #1 chk(1, "R9 irq disabled", done_irq_n, 1);
    // DMA on but masked; start also clears out_rdy
    dma_en = 1; dma_mask = 0;
    start(64);
    chk(1, "R2 start clears out_rdy", out_rdy, 0);
    chk(1, "R10 masked req", dma_req, 0);
    send(4, 16, 0); wait_out(); cyc(1);
    chk(1, "R10 no requests", dmas - d0, 0);
    dma_en = 0; dma_mask = 0;

    // back-pressure with slow core
    lat = 60; s0 = starts;
    start(192);
    chk(1, "R2 msg_bytes cleared", msg_bytes, 0);
    send(5, 16, 0); send(6, 16, 0);
    chk(1, "R4 held while busy", in_rdy, 0);
    chk(1, "R4 one launch so far", starts - s0, 1);
    send(9, 1, 0);
    chk(1, "R5 overrun on full", overrun, 1);
    wait_start(s0 + 2);
    check_blk("R4 held block", 6, 16);
    cyc(2);
    chk(1, "R4 reopened", in_rdy, 1);
    send(7, 16, 0); wait_start(s0 + 3);
    check_blk("R5 dropped word ignored", 7, 16);
    wait_out(); cyc(1);
    chk(1, "R7 msg_bytes 192", msg_bytes, 192);
    start(4096);
    chk(1, "R5 start clears overrun", overrun, 0);

    // R6 close with nothing pending
    lat = 3; s0 = starts;
    pulse_close(); cyc(5);
    chk(1, "R6 empty close ignored", starts - s0, 0);
    chk(1, "R6 still ready", in_rdy, 1);

    // length ending in a partial block
    start(100);
    send(8, 16, 0); wait_start(s0 + 1);
    chk(1, "R7 100B first not last", cap_last, 0);
    send(10, 9, 1); wait_start(s0 + 2);
    chk(1, "R6 partial nbytes", cap_nb, 36);
    chk(1, "R6 partial last", cap_last, 1);
    check_blk("R6 partial words", 10, 9);
    wait_out(); cyc(1);
    chk(1, "R7 msg_bytes 100", msg_bytes, 100);

    // R6 sweep over all fill levels
    for (int n = 1; n < 16; n++) begin
      s0 = starts;
      start(4096);
      if (n % 2 == 1) send(20 + n, n, 1);
      else begin send(20 + n, n, 0); pulse_close(); end
      wait_start(s0 + 1);
      chk(1, "R6 sweep nbytes", cap_nb, 4 * n);
      chk(1, "R6 sweep last", cap_last, 1);
      check_blk("R6 sweep words", 20 + n, n);
      wait_out(); cyc(1);
      chk(1, "R8 sweep out_rdy", out_rdy, 1);
      chk(1, "R7 sweep msg_bytes", msg_bytes, 4 * n);
    end
    summary();
  end
endmodule